// File: doc/BRIEF.md
# Read-only status responder on a two-wire serial bus

This block is a target on a two-wire serial bus (I2C) whose only job is to answer read requests with one 8-bit status word. A controller sends a START, a 7-bit address and a read bit. If the address matches, the block acknowledges and shifts the status word out MSB first. It keeps sending fresh copies for as long as the controller acknowledges each byte. When the controller declines a byte, the block lets go of the data line so the controller can finish with a STOP.

The status word is assembled from live inputs. Bit 7 is a sticky power-on flag, bit 6 is a lock indicator, bits 5..3 are three port levels, and bits 2..0 are a level code derived from four comparator outputs. Bus lines are sampled by a faster system clock through two-flop synchronizers, and the data line is an open-drain output expressed as a drive-low enable.

Top module: `stat_i2c_slave`

## Requirements
- R1: The block acknowledges, by driving SDA low during the ninth clock, only an address byte equal to {1,1,0,0,0,addr_sel[1],addr_sel[0],1}, where the eighth bit being 1 means a read.
- R2: An address byte that differs in any position, including a read/write bit of 0, gets no acknowledge, and SDA stays released for every clock until the next START.
- R3: The status byte is sent MSB first as {por, lock, port[2], port[1], port[0], code[2:0]}. A 0 bit is sent by driving SDA low and a 1 bit by releasing it.
- R4: The code counts the highest set comparator bit. If cmp[3] is set the code is 100, else if cmp[2] is set it is 011, else if cmp[1] is set it is 010, else if cmp[0] is set it is 001, and otherwise it is 000. Non-monotonic patterns follow the same rule.
- R5: A controller acknowledge after a status byte makes the block send another status byte, sampled anew.
- R6: A controller not-acknowledge after a status byte leaves SDA released and clears the power-on flag.
- R7: The power-on flag is 1 after reset and after any cycle with pwr_low high. Neither reads that the controller acknowledges nor writes clear it.
- R8: The fields of a status byte are captured at the SCL falling edge just before its first bit, so input changes in the middle of a byte do not alter that byte.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A START seen in the middle of an address byte restarts address reception from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset, acts as power-on |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Low two bits of the address |
| pwr_low | input | 1 | Supply-low pulse, sets the power-on flag |
| lock_i | input | 1 | Loop lock indicator |
| port_lvl | input | 3 | Port levels [2:0] |
| cmp_therm | input | 4 | Comparator outputs, lowest threshold in bit 0 |

## Verification
The assertions assume that addr_sel stays constant during a transaction. They also assume the controller never raises or lowers SDA while SCL is high, except to form a START or STOP. From that they conclude that the block's own drive changes only after an SCL fall. The bench changes SDA only a quarter bit period after SCL goes low, holds addr_sel fixed within each transaction, and makes every bus phase last many system clocks, so the two-flop synchronizers never see the two lines move together.

// File: rtl/stat_i2c_slave.sv
module stat_i2c_slave #(
  parameter logic [4:0] ADDR_HI = 5'b11000,
  parameter int         SYNC    = 2,
  parameter int         NPORT   = 3,
  parameter int         NLVL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_sel,
  input  logic             pwr_low,
  input  logic             lock_i,
  input  logic [NPORT-1:0] port_lvl,
  input  logic [NLVL-1:0]  cmp_therm
);
  localparam int CW = $clog2(NLVL + 1);
  localparam int SW = 2 + NPORT + CW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_SEND, S_MACK} st_t;

  st_t             st;
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_q, sda_q, por, mack;
  logic [7:0]      sh;
  logic [SW-1:0]   tx;
  logic [3:0]      cnt;
  logic [CW-1:0]   code;

  wire scl_s    = scl_sh[SYNC-1];
  wire sda_s    = sda_sh[SYNC-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire nack_c   = (st == S_MACK) & scl_rise & sda_s;
  wire [7:0] my_addr = {ADDR_HI, addr_sel, 1'b1};

  always_comb begin
    code = '0;
    for (int i = 0; i < NLVL; i++)
      if (cmp_therm[i]) code = CW'(i + 1);
  end

  wire [SW-1:0] status = {por, lock_i, port_lvl, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      por    <= 1'b1;
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      mack   <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (pwr_low)     por <= 1'b1;
      else if (nack_c) por <= 1'b0;

      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh == my_addr) begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_ACK:
            if (scl_fall) begin
              tx     <= status;
              sda_oe <= ~status[SW-1];
              cnt    <= '0;
              st     <= S_SEND;
            end
          S_SEND:
            if (scl_fall) begin
              if (cnt == 4'(SW - 1)) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~tx[SW-2];
                tx     <= tx << 1;
                cnt    <= cnt + 4'd1;
              end
            end
          S_MACK:
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= status;
                sda_oe <= ~status[SW-1];
                cnt    <= '0;
                st     <= S_SEND;
              end else begin
                st <= S_IDLE;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |-> (sda_oe && sh == my_addr));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  p_mack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK) |-> !sda_oe);
  p_por_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_low) |-> por);
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/stat_i2c_slave_tb.sv
module stat_i2c_slave_tb;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] sel = 2'b10;
  logic       pwr_low = 1'b0;
  logic       lock = 1'b0;
  logic [2:0] port = 3'b000;
  logic [3:0] therm = 4'b0000;
  logic       sda_oe;
  wire        sda_line = sda_oe ? 1'b0 : m_sda;

  int total = 0;
  int fails = 0;
  int r9_viol = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       ev_byte;

  always #2.5 clk = ~clk;

  stat_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(sel), .pwr_low(pwr_low), .lock_i(lock), .port_lvl(port),
    .cmp_therm(therm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input logic [3:0] t);
    if (t[3]) return 3'b100;
    if (t[2]) return 3'b011;
    if (t[1]) return 3'b010;
    if (t[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [7:0] stat_of(input bit p, input bit l, input logic [2:0] pt,
                                         input logic [3:0] t);
    return {p, l, pt, code_of(t)};
  endfunction

  initial forever begin
    @(ev_byte);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected byte", obs, 0);
    end else begin
      logic [7:0] e;
      string      tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk(obs == e, tg, obs, e);
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl) r9_viol++;
    prev_oe <= sda_oe;
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic read_bit(output bit b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_addr(input logic [7:0] a, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    read_bit(b);
    acked = !b;
  endtask

  task automatic read_byte(input int chg_at, input logic [2:0] newport);
    bit b;
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      if (i == chg_at) port = newport;
      read_bit(b);
      v = {v[6:0], b};
    end
    obs = v;
    -> ev_byte;
  endtask

  task automatic push(input logic [7:0] e, input string tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  task automatic read_one(input bit por_exp, input string tg);
    bit ack;
    bus_start();
    send_addr({5'b11000, sel, 1'b1}, ack);
    chk(ack, "R1 address ack", ack, 1);
    push(stat_of(por_exp, lock, port, therm), tg);
    read_byte(-1, 3'b000);
    send_bit(1'b1);
    chk(sda_line == 1'b1, "R6 SDA released after nack", sda_line, 1);
    bus_stop();
  endtask

  task automatic finish_run();
    chk(r9_viol == 0, "R9 SDA drive changed while SCL high", r9_viol, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ack, b, quiet;
    repeat (10) @(posedge clk);
    #1;
    chk(sda_line == 1'b1, "R2 released after reset", sda_line, 1);
    rst_n = 1'b1;
    wq();

    // R1 R3 R5 R7: two-byte read, POR still set in the second byte
    lock = 1'b1; port = 3'b101; therm = 4'b0011;
    bus_start();
    send_addr({5'b11000, sel, 1'b1}, ack);
    chk(ack, "R1 ack on matching read", ack, 1);
    push(stat_of(1'b1, 1'b1, 3'b101, 4'b0011), "R3 first byte layout");
    read_byte(-1, 3'b000);
    send_bit(1'b0);
    push(stat_of(1'b1, 1'b1, 3'b101, 4'b0011), "R7 POR sticky across acked byte");
    read_byte(-1, 3'b000);
    send_bit(1'b1);
    bus_stop();

    // R6: POR cleared by the nack
    lock = 1'b0; port = 3'b010; therm = 4'b0000;
    read_one(1'b0, "R6 POR cleared after nack");

    // R4: level codes, including non-monotonic patterns
    therm = 4'b0001; read_one(1'b0, "R4 code 001");
    therm = 4'b0111; read_one(1'b0, "R4 code 011");
    therm = 4'b1111; read_one(1'b0, "R4 code 100");
    therm = 4'b0101; read_one(1'b0, "R4 nonmono 0101");
    therm = 4'b1000; read_one(1'b0, "R4 nonmono 1000");

    // R2: wrong address bit, then stay quiet
    bus_start();
    send_addr({5'b11000, ~sel[1], sel[0], 1'b1}, ack);
    chk(!ack, "R2 no ack on mismatched address", ack, 0);
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      read_bit(b);
      if (!b) quiet = 1'b0;
    end
    chk(quiet, "R2 silent after mismatch", quiet, 1);
    bus_stop();

    // R2 R7: write direction is not acknowledged and leaves POR clear
    bus_start();
    send_addr({5'b11000, sel, 1'b0}, ack);
    chk(!ack, "R2 no ack on write", ack, 0);
    bus_stop();
    therm = 4'b0010;
    read_one(1'b0, "R7 POR unaffected by write");

    // R7: supply-low pulse sets POR
    @(posedge clk); #1; pwr_low = 1'b1;
    @(posedge clk); #1; pwr_low = 1'b0;
    read_one(1'b1, "R7 POR set by supply-low");

    // R8 R5: port change mid-byte affects only the next byte
    sel = 2'b01; lock = 1'b1; port = 3'b110; therm = 4'b0100;
    bus_start();
    send_addr({5'b11000, sel, 1'b1}, ack);
    chk(ack, "R1 ack with other addr_sel", ack, 1);
    push(stat_of(1'b0, 1'b1, 3'b110, 4'b0100), "R8 byte stable mid-change");
    read_byte(3, 3'b001);
    send_bit(1'b0);
    push(stat_of(1'b0, 1'b1, 3'b001, 4'b0100), "R5 second byte resampled");
    read_byte(-1, 3'b000);
    send_bit(1'b1);
    bus_stop();

    // R10: repeated START inside an address byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_addr({5'b11000, sel, 1'b1}, ack);
    chk(ack, "R10 ack after restart mid-address", ack, 1);
    push(stat_of(1'b0, 1'b1, 3'b001, 4'b0100), "R10 byte after restart");
    read_byte(-1, 3'b000);
    send_bit(1'b1);
    bus_stop();

    wq();
    chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule